// File: doc/BRIEF.md
# GPIO Input Conditioner with Per-Pin Interrupts

This block takes up to sixteen asynchronous input pins and turns each one into a clean, debounced level that the rest of the chip can read, plus one interrupt request per pin. Each pin first passes through a two-flop synchronizer. It can then be inverted. After that a digital filter decides when the filtered level changes. The filter samples only on a strobe. Each pin picks its strobe from the 0-to-1 transitions of one bit of a shared free-running counter, so each pin sets its own sample rate. The filtered level changes only after a programmed number of consecutive samples all disagree with it.

Each pin raises its interrupt in one of two ways. In level mode the request follows the filtered value. In edge mode a sticky latch records every 0-to-1 transition of the filtered value. A per-pin enable gates the request onto the pin's interrupt output. Neighbouring register logic clears the edge latches with a one-cycle write strobe and a bit mask. A single combined line reports whether any enabled pin is requesting service. The filtered levels of all pins appear together on one data word.

Top module: `gpin_filter_irq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the data word, every per-pin interrupt and the combined interrupt are 0. The edge latches and the run counters are cleared.
- R2: Each raw pin is synchronized by two flops and then XORed with its invert bit (1 = invert). The data word shows the filtered version of that value.
- R3: A pin samples only on a strobe. The strobe is a 0-to-1 transition of the bit of the shared counter chosen by that pin's 4-bit rate field. Rate field k gives a sample period of 2^(k+1) cycles, so a larger field responds later.
- R4: With stability count C in the 4-bit count field, the filtered value changes only after C+1 consecutive samples that all differ from it. A sample equal to the filtered value restarts the run, so a shorter excursion leaves the filtered value unchanged.
- R5: With stability count 0 the filtered value takes the sampled value at the first strobe that sees a difference.
- R6: With the type bit at 0 (level mode) the pin's interrupt equals the filtered value ANDed with its enable bit. A clear write has no effect on it.
- R7: With the type bit at 1 (edge mode) a 0-to-1 change of the filtered value sets the pin's latch. The latch stays set after the level falls. Only a clear write with that pin's mask bit at 1 resets it, and the output drops one cycle after the write. Mask bits at 0 leave their latches alone, and a new edge in the same cycle as a clear wins.
- R8: The enable bit (1 = enabled) masks only the output. An edge latched while the pin is disabled appears on the interrupt as soon as the pin is enabled.
- R9: The combined interrupt is 1 exactly when at least one per-pin interrupt is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NUM_PINS | Asynchronous input pins |
| cfg_invert | input | NUM_PINS | Per-pin invert, 1 = invert |
| cfg_irq_en | input | NUM_PINS | Per-pin interrupt enable |
| cfg_irq_edge | input | NUM_PINS | Interrupt type, 0 = level, 1 = rising edge |
| cfg_rate_sel | input | NUM_PINS*4 | Per-pin counter-bit strobe select, pin i at [4i+3:4i] |
| cfg_stable_cnt | input | NUM_PINS*4 | Per-pin stability count, pin i at [4i+3:4i] |
| clr_wr | input | 1 | One-cycle write strobe for the edge-latch clear |
| clr_mask | input | NUM_PINS | Latches to clear on clr_wr, 1 = clear |
| rx_data | output | NUM_PINS | Filtered pin values |
| irq_pin | output | NUM_PINS | Per-pin interrupt requests |
| irq_any | output | 1 | OR of all per-pin interrupt requests |

## Verification
A run counter that is wrong inside the filter shows up on the data word as a change that comes one or more sample periods too early or too late, or as a glitch that gets through. The bench therefore brackets each change with a "still old" sample and a "now new" sample. A rate select that picks the wrong counter bit shifts the change by a power of two, and the test that compares a fast pin with a slow pin catches it within tens of cycles. A stuck or lost edge latch is visible on the pin's interrupt in the cycle after the edge or the clear, and a latch that was lost while the pin was masked is visible as soon as the enable is raised.

// File: rtl/gpin_pkg.sv
package gpin_pkg;

    localparam int DEF_PINS  = 16;
    localparam int DEF_SEL_W = 4;
    localparam int DEF_RUN_W = 4;

    // Per-pin configuration, unpacked from the flat input ports.
    typedef struct packed {
        logic [DEF_SEL_W-1:0] rate_sel;
        logic [DEF_RUN_W-1:0] stable_cnt;
        logic                 invert;
        logic                 irq_edge;
        logic                 irq_en;
    } pin_cfg_t;

    // Filter decision for one strobe.
    typedef enum logic [1:0] {
        FLT_HOLD    = 2'd0,
        FLT_RESTART = 2'd1,
        FLT_COUNT   = 2'd2,
        FLT_FLIP    = 2'd3
    } flt_step_e;

    function automatic flt_step_e flt_decide(
        input logic       tick,
        input logic       samp,
        input logic       filt,
        input logic [3:0] run,
        input logic [3:0] limit
    );
        if (!tick)            return FLT_HOLD;
        else if (samp == filt) return FLT_RESTART;
        else if (run >= limit) return FLT_FLIP;
        else                   return FLT_COUNT;
    endfunction

endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpin_strobe.sv
module gpin_strobe #(
    parameter int SEL_W = 4,
    localparam int CNT_W = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] rise_vec
);
    logic [CNT_W-1:0] tmr_q;
    logic [CNT_W-1:0] tmr_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q      <= '0;
            tmr_prev_q <= '0;
        end else begin
            tmr_q      <= tmr_q + 1'b1;
            tmr_prev_q <= tmr_q;
        end
    end

    // A bit that has just gone from 0 to 1 marks one strobe.
    assign rise_vec = tmr_q & ~tmr_prev_q;
endmodule

// File: rtl/gpin_lane.sv
module gpin_lane
    import gpin_pkg::*;
#(
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             samp,
    input  logic [RUN_W-1:0] stable_cnt,
    input  logic             irq_edge,
    input  logic             irq_en,
    input  logic             clr,
    output logic             filt,
    output logic             irq
);
    logic [RUN_W-1:0] run_q;
    logic             filt_q;
    logic             latch_q;
    flt_step_e        step;
    logic             rise_now;

    assign step     = flt_decide(tick, samp, filt_q, run_q, stable_cnt);
    assign rise_now = (step == FLT_FLIP) && samp;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            unique case (step)
                FLT_HOLD:    run_q <= run_q;
                FLT_RESTART: run_q <= '0;
                FLT_COUNT:   run_q <= run_q + 1'b1;
                FLT_FLIP: begin
                    run_q  <= '0;
                    filt_q <= samp;
                end
                default:     run_q <= run_q;
            endcase
        end
    end

    // Edge latch: a new edge takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)                       latch_q <= 1'b0;
        else if (irq_edge && rise_now) latch_q <= 1'b1;
        else if (clr)                  latch_q <= 1'b0;
    end

    assign filt = filt_q;
    assign irq  = irq_en & (irq_edge ? latch_q : filt_q);
endmodule

// File: rtl/gpin_filter_irq.sv
module gpin_filter_irq
    import gpin_pkg::*;
#(
    parameter int NUM_PINS = DEF_PINS,
    parameter int SEL_W    = DEF_SEL_W,
    parameter int RUN_W    = DEF_RUN_W,
    localparam int CNT_W   = 2 ** SEL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PINS-1:0]       pin_raw,
    input  logic [NUM_PINS-1:0]       cfg_invert,
    input  logic [NUM_PINS-1:0]       cfg_irq_en,
    input  logic [NUM_PINS-1:0]       cfg_irq_edge,
    input  logic [NUM_PINS*SEL_W-1:0] cfg_rate_sel,
    input  logic [NUM_PINS*RUN_W-1:0] cfg_stable_cnt,
    input  logic                      clr_wr,
    input  logic [NUM_PINS-1:0]       clr_mask,
    output logic [NUM_PINS-1:0]       rx_data,
    output logic [NUM_PINS-1:0]       irq_pin,
    output logic                      irq_any
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_strobe;
    logic [CNT_W-1:0]    rise_vec;

    gpin_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_raw),
        .q_sync  (pin_sync)
    );

    gpin_strobe #(.SEL_W(SEL_W)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .rise_vec (rise_vec)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic [SEL_W-1:0] sel_i;
            logic [RUN_W-1:0] cnt_i;
            logic             samp_i;

            assign sel_i         = cfg_rate_sel[i*SEL_W +: SEL_W];
            assign cnt_i         = cfg_stable_cnt[i*RUN_W +: RUN_W];
            assign samp_i        = pin_sync[i] ^ cfg_invert[i];
            assign pin_strobe[i] = rise_vec[sel_i];

            gpin_lane #(.RUN_W(RUN_W)) u_lane (
                .clk        (clk),
                .rst        (rst),
                .tick       (pin_strobe[i]),
                .samp       (samp_i),
                .stable_cnt (cnt_i),
                .irq_edge   (cfg_irq_edge[i]),
                .irq_en     (cfg_irq_en[i]),
                .clr        (clr_wr & clr_mask[i]),
                .filt       (rx_data[i]),
                .irq        (irq_pin[i])
            );
        end
    endgenerate

    assign irq_any = |irq_pin;
endmodule

// File: rtl/gpin_filter_irq_chk.sv
module gpin_filter_irq_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] rx_data,
    input logic [NUM_PINS-1:0] irq_pin,
    input logic                irq_any,
    input logic [NUM_PINS-1:0] cfg_irq_edge,
    input logic [NUM_PINS-1:0] cfg_irq_en,
    input logic                clr_wr,
    input logic [NUM_PINS-1:0] clr_mask,
    input logic [NUM_PINS-1:0] pin_strobe
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rx_data == '0 && irq_pin == '0 && !irq_any));

    assert_any_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ($countones(irq_pin) == 0) |-> !irq_any);

    assert_any_busy_R9: assert property (@(posedge clk) disable iff (rst)
        ($countones(irq_pin) != 0) |-> irq_any);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
            assert_change_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
                !$stable(rx_data[i]) |-> $past(pin_strobe[i]));

            assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
                !cfg_irq_edge[i] |-> (irq_pin[i] == (rx_data[i] & cfg_irq_en[i])));

            assert_edge_sets_R7: assert property (@(posedge clk) disable iff (rst)
                ($rose(rx_data[i]) && $past(cfg_irq_edge[i]) && cfg_irq_edge[i]
                 && cfg_irq_en[i]) |-> irq_pin[i]);

            assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (rst)
                ($past(irq_pin[i]) && $past(cfg_irq_edge[i]) && cfg_irq_edge[i]
                 && $past(cfg_irq_en[i]) && cfg_irq_en[i]
                 && !$past(clr_wr && clr_mask[i])) |-> irq_pin[i]);

            assert_masked_low_R8: assert property (@(posedge clk) disable iff (rst)
                !cfg_irq_en[i] |-> !irq_pin[i]);
        end
    endgenerate
endmodule

bind gpin_filter_irq gpin_filter_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_data      (rx_data),
    .irq_pin      (irq_pin),
    .irq_any      (irq_any),
    .cfg_irq_edge (cfg_irq_edge),
    .cfg_irq_en   (cfg_irq_en),
    .clr_wr       (clr_wr),
    .clr_mask     (clr_mask),
    .pin_strobe   (pin_strobe)
);

// File: tb/gpin_filter_irq_tb_top.sv
module gpin_filter_irq_tb_top;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] cfg_invert = '0;
    logic [NP-1:0] cfg_irq_en = '0;
    logic [NP-1:0] cfg_irq_edge = '0;
    logic [NP*4-1:0] cfg_rate_sel = '0;
    logic [NP*4-1:0] cfg_stable_cnt = '0;
    logic          clr_wr = 1'b0;
    logic [NP-1:0] clr_mask = '0;
    logic [NP-1:0] rx_data;
    logic [NP-1:0] irq_pin;
    logic          irq_any;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gpin_filter_irq dut_i (
        .clk            (clk),
        .rst            (rst),
        .pin_raw        (pin_raw),
        .cfg_invert     (cfg_invert),
        .cfg_irq_en     (cfg_irq_en),
        .cfg_irq_edge   (cfg_irq_edge),
        .cfg_rate_sel   (cfg_rate_sel),
        .cfg_stable_cnt (cfg_stable_cnt),
        .clr_wr         (clr_wr),
        .clr_mask       (clr_mask),
        .rx_data        (rx_data),
        .irq_pin        (irq_pin),
        .irq_any        (irq_any)
    );

    // Vector: {pin[3:0], rate[3:0], count[3:0], invert, raw, expected}
    localparam int NV = 7;
    localparam logic [14:0] VEC [NV] = '{
        {4'd0, 4'd0, 4'd0,  1'b0, 1'b1, 1'b1},
        {4'd0, 4'd0, 4'd0,  1'b1, 1'b1, 1'b0},
        {4'd5, 4'd1, 4'd2,  1'b1, 1'b0, 1'b1},
        {4'd5, 4'd3, 4'd5,  1'b0, 1'b0, 1'b0},
        {4'd6, 4'd2, 4'd15, 1'b0, 1'b1, 1'b1},
        {4'd7, 4'd4, 4'd1,  1'b1, 1'b0, 1'b1},
        {4'd0, 4'd0, 4'd0,  1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_pin(input int p, input logic [3:0] rate, input logic [3:0] cnt,
                           input logic inv, input logic edge_m, input logic en);
        cfg_rate_sel[p*4 +: 4]   = rate;
        cfg_stable_cnt[p*4 +: 4] = cnt;
        cfg_invert[p]            = inv;
        cfg_irq_edge[p]          = edge_m;
        cfg_irq_en[p]            = en;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [NP-1:0] m);
        clr_mask = m;
        clr_wr   = 1'b1;
        @(negedge clk);
        clr_wr   = 1'b0;
        clr_mask = '0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_n(4);
        // R1: outputs cleared while in reset
        check("R1 data in reset", 32'(rx_data), 0);
        check("R1 irq in reset", {irq_any, 15'd0, irq_pin}, 0);
        pin_raw = '1;
        cfg_irq_en = '1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 first cycle after reset", {irq_any, 15'd0, rx_data}, 0);
        rst = 1'b1;
        pin_raw = '0;
        cfg_irq_en = '0;
        wait_n(2);
        rst = 1'b0;
        wait_n(2);

        // R2 R5: table walk of rate, count and invert settings
        for (int v = 0; v < NV; v++) begin
            int p;
            p = int'(VEC[v][14:11]);
            set_pin(p, VEC[v][10:7], VEC[v][6:3], VEC[v][2], 1'b0, 1'b0);
            pin_raw[p] = VEC[v][1];
            wait_n((int'(VEC[v][6:3]) + 1) * (2 << VEC[v][10:7]) + 8);
            check($sformatf("R2 R5 vector %0d", v), 32'(rx_data[p]), 32'(VEC[v][0]));
        end

        // R4: pin 1, rate 2 (period 8), count 3 needs 4 samples
        set_pin(1, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0);
        wait_n(2);
        pin_raw[1] = 1'b1;
        wait_n(24);
        check("R4 not yet changed", 32'(rx_data[1]), 0);
        wait_n(14);
        check("R4 changed after count", 32'(rx_data[1]), 1);
        pin_raw[1] = 1'b0;
        wait_n(12);
        pin_raw[1] = 1'b1;
        wait_n(50);
        check("R4 short excursion ignored", 32'(rx_data[1]), 1);

        // R3: pin 8 rate 0 vs pin 9 rate 4, both count 1
        set_pin(8, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0);
        set_pin(9, 4'd4, 4'd1, 1'b0, 1'b0, 1'b0);
        wait_n(2);
        pin_raw[8] = 1'b1;
        pin_raw[9] = 1'b1;
        wait_n(10);
        check("R3 fast pin updated", 32'(rx_data[8]), 1);
        check("R3 slow pin still old", 32'(rx_data[9]), 0);
        wait_n(80);
        check("R3 slow pin updated", 32'(rx_data[9]), 1);

        // R9: nothing enabled yet
        check("R9 idle combined", 32'(irq_any), 0);

        // R6: level mode on pin 2
        set_pin(2, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1);
        pin_raw[2] = 1'b1;
        wait_n(8);
        check("R6 level irq", 32'(irq_pin[2]), 1);
        check("R9 combined follows", 32'(irq_any), 1);
        pulse_clear(16'h0004);
        check("R6 clear ignored", 32'(irq_pin[2]), 1);
        cfg_irq_en[2] = 1'b0;
        #1;
        check("R6 enable masks", 32'(irq_pin[2]), 0);
        cfg_irq_en[2] = 1'b1;
        pin_raw[2] = 1'b0;
        wait_n(8);
        check("R6 level low", 32'(irq_pin[2]), 0);
        cfg_irq_en[2] = 1'b0;

        // R7: edge mode on pin 3
        set_pin(3, 4'd0, 4'd0, 1'b0, 1'b1, 1'b1);
        pin_raw[3] = 1'b1;
        wait_n(8);
        check("R7 edge latched", 32'(irq_pin[3]), 1);
        pin_raw[3] = 1'b0;
        wait_n(8);
        check("R7 sticky after fall", 32'(irq_pin[3]), 1);
        pulse_clear(16'hFFF7);
        check("R7 other mask bits", 32'(irq_pin[3]), 1);
        pulse_clear(16'h0008);
        check("R7 cleared", 32'(irq_pin[3]), 0);
        check("R9 combined clears", 32'(irq_any), 0);

        // R8: edge while disabled shows on enable
        cfg_irq_en[3] = 1'b0;
        pin_raw[3] = 1'b1;
        wait_n(8);
        check("R8 masked output", 32'(irq_pin[3]), 0);
        cfg_irq_en[3] = 1'b1;
        #1;
        check("R8 latched while masked", 32'(irq_pin[3]), 1);

        wait_n(2);
        finish_run();
    end
endmodule